// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 interrupt request lines into two level outputs, a normal request and a critical request, for a processor core. Software reaches its registers through a plain register port: a 4-bit register offset, write data with a write strobe, and a read strobe that returns read data in the same cycle. Each source can be edge- or level-sensitive and can be steered to either output. Only enabled sources count.

For critical sources the block also produces a vector address. The vector is a programmable base plus a 512-byte stride times the position of the first pending critical source. A configuration bit picks whether the scan runs up from bit 0 or down from bit 31. Level-sensitive sources keep a separate copy of their input state. That copy forces a status bit back on after software clears it, for as long as the source is still driving.

The block holds no sequencing state. Every register has one state, "active", and moves through one transition, asynchronous reset to active. After that, each clock edge applies the register write first and then the input events.

Top module: `irqv_top`

## Requirements
- R1: While reset is asserted, the status, level copy, enable, critical, polarity, trigger and vector-configuration registers are zero. Both outputs are low, and every offset reads 0.
- R2: Input n maps to status bit (31 − n), so input 0 is the most significant bit. A source with trigger bit 0 is level-sensitive. When its input differs from the stored level copy, the status bit and the level copy both take the input value.
- R3: A source with trigger bit 1 is edge-sensitive. A high input sets its status bit. A low input never clears it.
- R4: Writing offset 0 clears every status bit written as 1 and then ORs back the level copy. Writing offset 1 ORs the written value into status.
- R5: The normal output is high exactly when (status & enable & ~critical) is nonzero. The critical output is high exactly when (status & enable & critical) is nonzero.
- R6: Offset 6 reads status & enable. Writes to offsets 6 and 7 change no register.
- R7: When vector-config bit 0 is 0, offset 7 reads (config with bits 1:0 cleared) + 512 × i, where i is the lowest-numbered bit of status & enable & critical.
- R8: When vector-config bit 0 is 1, the scan starts at bit 31 and moves down. Offset 7 reads (config with bits 1:0 cleared) + 512 × (31 − i), where i is the highest-numbered pending critical bit.
- R9: Offset 7 reads 0 whenever no enabled critical source is pending.
- R10: A write to offset 8 stores the data with bit 1 forced to 0. When parameter HAS_VEC is 0, offsets 7 and 8 read 0.
- R11: The register map is: 0 status, 1 status-set (reads status), 2 enable, 3 critical, 4 polarity (stored only), 5 trigger, 6 masked status, 7 vector, 8 vector config. Offsets 2 to 5 read back the last value written. Unused offsets read 0, and writes to them have no effect.
- R12: All effects become visible right after the clock edge that applies them. Within one edge, the write is applied before the input event, and the input event uses the trigger setting held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NSRC | Interrupt request lines; line n maps to status bit NSRC-1-n |
| reg_addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | NSRC | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | NSRC | Read data, combinational; 0 when rd_en is low |
| irq_norm_o | output | 1 | Normal interrupt request |
| irq_crit_o | output | 1 | Critical interrupt request |

## Verification
The bench builds one instance with the defaults (32 sources, HAS_VEC = 1, a 512-byte stride). With this instance both scan directions, the bit-1 masking of the configuration and the full-width vector sums can be observed. A second instance with HAS_VEC = 0 shares the same bus, which exposes the zero reads of offsets 7 and 8 when the vector feature is left out. Random writes to the trigger, enable and critical registers, mixed with input toggles, reach the edge and level mixtures, and the bench's register model predicts every read.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    typedef enum logic [3:0] {
        OFS_STAT = 4'd0,
        OFS_SET  = 4'd1,
        OFS_ENA  = 4'd2,
        OFS_CRIT = 4'd3,
        OFS_POL  = 4'd4,
        OFS_TRIG = 4'd5,
        OFS_MSK  = 4'd6,
        OFS_VEC  = 4'd7,
        OFS_VCFG = 4'd8
    } irqv_ofs_e;
endpackage

// File: rtl/irqv_srcbank.sv
module irqv_srcbank #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] in_bits,
    input  logic [NSRC-1:0] trig,
    input  logic            clr_wr,
    input  logic            set_wr,
    input  logic [NSRC-1:0] wmask,
    output logic [NSRC-1:0] st_q,
    output logic [NSRC-1:0] lvl_q
);
    for (genvar b = 0; b < NSRC; b++) begin : g_bit
        logic s_r, l_r, s_sw, s_n, l_n;

        // software effect first, then the input event
        always_comb begin
            s_sw = s_r;
            if (clr_wr)
                s_sw = (s_r & ~wmask[b]) | l_r;
            else if (set_wr)
                s_sw = s_r | wmask[b];
            s_n = s_sw;
            l_n = l_r;
            if (trig[b]) begin
                if (in_bits[b]) s_n = 1'b1;
            end else begin
                l_n = in_bits[b];
                if (in_bits[b] != l_r) s_n = in_bits[b];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s_r <= 1'b0;
                l_r <= 1'b0;
            end else begin
                s_r <= s_n;
                l_r <= l_n;
            end
        end

        assign st_q[b]  = s_r;
        assign lvl_q[b] = l_r;
    end
endmodule

// File: rtl/irqv_vecgen.sv
module irqv_vecgen #(
    parameter int NSRC   = 32,
    parameter int VEC_SH = 9
) (
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] vcfg,
    output logic [NSRC-1:0] vec
);
    localparam int IW = $clog2(NSRC);

    logic [IW-1:0]   idx_lo, idx_hi;
    logic [NSRC-1:0] off;

    always_comb begin
        idx_lo = '0;
        idx_hi = '0;
        for (int i = NSRC - 1; i >= 0; i--)
            if (pend[i]) idx_lo = IW'(i);
        for (int i = 0; i < NSRC; i++)
            if (pend[i]) idx_hi = IW'(i);
        if (vcfg[0])
            off = NSRC'(NSRC - 1) - NSRC'(idx_hi);
        else
            off = NSRC'(idx_lo);
        if (|pend)
            vec = (vcfg & ~NSRC'(3)) + (off << VEC_SH);
        else
            vec = '0;
    end
endmodule

// File: rtl/irqv_top.sv
module irqv_top
    import irqv_pkg::*;
#(
    parameter int NSRC    = 32,
    parameter bit HAS_VEC = 1'b1,
    parameter int VEC_SH  = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_in,
    input  logic [3:0]      reg_addr,
    input  logic            wr_en,
    input  logic [NSRC-1:0] wr_data,
    input  logic            rd_en,
    output logic [NSRC-1:0] rd_data,
    output logic            irq_norm_o,
    output logic            irq_crit_o
);
    logic [NSRC-1:0] en_q, cr_q, pol_q, trig_q, vcfg_q;
    logic [NSRC-1:0] st_q, lvl_q, in_bits, pend, vec_raw, vec_w;

    // line n lands on status bit NSRC-1-n
    for (genvar n = 0; n < NSRC; n++) begin : g_rev
        assign in_bits[NSRC-1-n] = irq_in[n];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            cr_q   <= '0;
            pol_q  <= '0;
            trig_q <= '0;
        end else if (wr_en) begin
            unique case (reg_addr)
                OFS_ENA:  en_q   <= wr_data;
                OFS_CRIT: cr_q   <= wr_data;
                OFS_POL:  pol_q  <= wr_data;
                OFS_TRIG: trig_q <= wr_data;
                default:  ;
            endcase
        end
    end

    if (HAS_VEC) begin : g_vcfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                vcfg_q <= '0;
            else if (wr_en && reg_addr == OFS_VCFG)
                vcfg_q <= wr_data & ~NSRC'(2);
        end
    end else begin : g_novcfg
        assign vcfg_q = '0;
    end

    irqv_srcbank #(.NSRC(NSRC)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_bits (in_bits),
        .trig    (trig_q),
        .clr_wr  (wr_en && reg_addr == OFS_STAT),
        .set_wr  (wr_en && reg_addr == OFS_SET),
        .wmask   (wr_data),
        .st_q    (st_q),
        .lvl_q   (lvl_q)
    );

    assign pend       = st_q & en_q & cr_q;
    assign irq_crit_o = |pend;
    assign irq_norm_o = |(st_q & en_q & ~cr_q);

    irqv_vecgen #(.NSRC(NSRC), .VEC_SH(VEC_SH)) u_vec (
        .pend (pend),
        .vcfg (vcfg_q),
        .vec  (vec_raw)
    );

    assign vec_w = HAS_VEC ? vec_raw : '0;

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (reg_addr)
                OFS_STAT, OFS_SET: rd_data = st_q;
                OFS_ENA:           rd_data = en_q;
                OFS_CRIT:          rd_data = cr_q;
                OFS_POL:           rd_data = pol_q;
                OFS_TRIG:          rd_data = trig_q;
                OFS_MSK:           rd_data = st_q & en_q;
                OFS_VEC:           rd_data = vec_w;
                OFS_VCFG:          rd_data = vcfg_q;
                default:           rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
    parameter int NSRC    = 32,
    parameter bit HAS_VEC = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [3:0]      reg_addr,
    input logic [NSRC-1:0] wr_data,
    input logic [NSRC-1:0] st_q,
    input logic [NSRC-1:0] lvl_q,
    input logic [NSRC-1:0] in_bits,
    input logic [NSRC-1:0] trig_q,
    input logic [NSRC-1:0] en_q,
    input logic [NSRC-1:0] cr_q,
    input logic [NSRC-1:0] vcfg_q,
    input logic [NSRC-1:0] vec_w,
    input logic            irq_norm_o,
    input logic            irq_crit_o
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!irq_norm_o && !irq_crit_o && st_q == '0 && en_q == '0));

    // edge-sensitive bits that are set survive any cycle without a status clear
    assert_edge_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_addr == 4'd0) |=>
            ((st_q & $past(st_q & trig_q)) == $past(st_q & trig_q)));

    // clearing status cannot drop a level source whose input holds still
    assert_level_reassert_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == 4'd0 && (((in_bits ^ lvl_q) & ~trig_q) == '0)) |=>
            ((st_q & $past(lvl_q & ~trig_q)) == $past(lvl_q & ~trig_q)));

    assert_ro_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (reg_addr == 4'd6 || reg_addr == 4'd7)) |=>
            ($stable(en_q) && $stable(cr_q) && $stable(trig_q) && $stable(vcfg_q)));

    assert_vec_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_crit_o |-> (vec_w == '0));

    if (HAS_VEC) begin : g_vc
        assert_vcfg_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && reg_addr == 4'd8) |=> (vcfg_q == ($past(wr_data) & ~NSRC'(2))));
    end else begin : g_nvc
        assert_vcfg_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (vcfg_q == '0) && (vec_w == '0));
    end
endmodule

bind irqv_top irqv_chk #(.NSRC(NSRC), .HAS_VEC(HAS_VEC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .reg_addr   (reg_addr),
    .wr_data    (wr_data),
    .st_q       (st_q),
    .lvl_q      (lvl_q),
    .in_bits    (in_bits),
    .trig_q     (trig_q),
    .en_q       (en_q),
    .cr_q       (cr_q),
    .vcfg_q     (vcfg_q),
    .vec_w      (vec_w),
    .irq_norm_o (irq_norm_o),
    .irq_crit_o (irq_crit_o)
);

// File: tb/sim_irqv_top.sv
`timescale 1ns/1ps
module sim_irqv_top;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] irq_in;
    logic [3:0]   addr;
    logic         wr_en, rd_en;
    logic [N-1:0] wdata, rdata0, rdata1;
    logic         norm0, crit0, norm1, crit1;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irqv_top #(.NSRC(N), .HAS_VEC(1'b1), .VEC_SH(9)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(addr),
        .wr_en(wr_en), .wr_data(wdata), .rd_en(rd_en), .rd_data(rdata0),
        .irq_norm_o(norm0), .irq_crit_o(crit0));

    irqv_top #(.NSRC(N), .HAS_VEC(1'b0), .VEC_SH(9)) u1 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(addr),
        .wr_en(wr_en), .wr_data(wdata), .rd_en(rd_en), .rd_data(rdata1),
        .irq_norm_o(norm1), .irq_crit_o(crit1));

    // register model built from the requirements
    logic [N-1:0] m_st, m_lv, m_en, m_cr, m_pl, m_tr, m_vc;

    always @(posedge clk or negedge rst_n) begin : model
        logic [N-1:0] inb, s, l;
        if (!rst_n) begin
            m_st = '0; m_lv = '0; m_en = '0; m_cr = '0;
            m_pl = '0; m_tr = '0; m_vc = '0;
        end else begin
            for (int n = 0; n < N; n++) inb[N-1-n] = irq_in[n];
            s = m_st;
            l = m_lv;
            if (wr_en && addr == 4'd0) s = (m_st & ~wdata) | m_lv;
            if (wr_en && addr == 4'd1) s = m_st | wdata;
            for (int b = 0; b < N; b++) begin
                if (m_tr[b]) begin
                    if (inb[b]) s[b] = 1'b1;
                end else begin
                    if (inb[b] != m_lv[b]) s[b] = inb[b];
                    l[b] = inb[b];
                end
            end
            if (wr_en) begin
                case (addr)
                    4'd2: m_en = wdata;
                    4'd3: m_cr = wdata;
                    4'd4: m_pl = wdata;
                    4'd5: m_tr = wdata;
                    4'd8: m_vc = wdata & ~32'h2;
                    default: ;
                endcase
            end
            m_st = s;
            m_lv = l;
        end
    end

    function automatic logic [N-1:0] exp_vec();
        logic [N-1:0] p;
        p = m_st & m_en & m_cr;
        if (p == '0) return '0;
        if (m_vc[0]) begin
            for (int i = N - 1; i >= 0; i--)
                if (p[i]) return (m_vc & ~32'h3) + 32'((N - 1 - i) * 512);
        end else begin
            for (int i = 0; i < N; i++)
                if (p[i]) return (m_vc & ~32'h3) + 32'(i * 512);
        end
        return '0;
    endfunction

    function automatic logic [N-1:0] exp_rd(input logic [3:0] a);
        case (a)
            4'd0, 4'd1: return m_st;
            4'd2: return m_en;
            4'd3: return m_cr;
            4'd4: return m_pl;
            4'd5: return m_tr;
            4'd6: return m_st & m_en;
            4'd7: return exp_vec();
            4'd8: return m_vc;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [N-1:0] v0, output logic [N-1:0] v1);
        addr = a; rd_en = 1'b1;
        #1;
        v0 = rdata0; v1 = rdata1;
        rd_en = 1'b0;
    endtask

    task automatic chk_rd(input string tag, input logic [3:0] a);
        logic [N-1:0] v0, v1;
        rd(a, v0, v1);
        chk(tag, v0, exp_rd(a));
    endtask

    task automatic chk_outs(input string tag);
        chk({tag, " norm R5"}, {31'b0, norm0}, {31'b0, |(m_st & m_en & ~m_cr)});
        chk({tag, " crit R5"}, {31'b0, crit0}, {31'b0, |(m_st & m_en & m_cr)});
    endtask

    task automatic set_in(input int n, input logic v);
        @(negedge clk);
        irq_in[n] = v;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v0, v1;
        void'($urandom(32'd7351));
        rst_n = 1'b0; irq_in = '0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("reset norm R1", {31'b0, norm0}, '0);
        chk("reset crit R1", {31'b0, crit0}, '0);
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v0, v1);
            chk("reset read R1", v0, '0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R3 edge: input 0 is status bit 31
        wr(4'd5, 32'h8000_0000);
        set_in(0, 1'b1);
        set_in(0, 1'b0);
        rd(4'd0, v0, v1); chk("edge sticky R3", v0, 32'h8000_0000);
        wr(4'd0, 32'h8000_0000);
        rd(4'd0, v0, v1); chk("edge clear R4", v0, 32'h0);

        // R2 level: input 1 is status bit 30
        set_in(1, 1'b1);
        rd(4'd0, v0, v1); chk("level follow R2", v0, 32'h4000_0000);
        wr(4'd0, 32'h4000_0000);
        rd(4'd0, v0, v1); chk("level reassert R4", v0, 32'h4000_0000);
        set_in(1, 1'b0);
        rd(4'd0, v0, v1); chk("level drop R2", v0, 32'h0);

        // R5 R6 enable masking, status-set
        wr(4'd1, 32'h0000_0001);
        rd(4'd1, v0, v1); chk("set reads status R11", v0, 32'h1);
        chk("masked norm R5", {31'b0, norm0}, '0);
        rd(4'd6, v0, v1); chk("masked read R6", v0, 32'h0);
        wr(4'd2, 32'hFFFF_FFFF);
        chk("enabled norm R5", {31'b0, norm0}, 32'h1);
        rd(4'd6, v0, v1); chk("masked read en R6", v0, 32'h1);

        // R7 R8 critical vectors
        wr(4'd3, 32'h0001_0010);
        wr(4'd1, 32'h0001_0010);
        chk("crit out R5", {31'b0, crit0}, 32'h1);
        wr(4'd8, 32'h0001_0003);
        rd(4'd8, v0, v1); chk("vcfg bit1 R10", v0, 32'h0001_0001);
        chk("vcfg off u1 R10", v1, 32'h0);
        rd(4'd7, v0, v1); chk("vector down R8", v0, 32'h0001_1E00);
        chk("vector off u1 R10", v1, 32'h0);
        wr(4'd8, 32'h0001_0000);
        rd(4'd7, v0, v1); chk("vector up R7", v0, 32'h0001_0800);

        // R6 ignored writes
        wr(4'd6, 32'hFFFF_FFFF);
        wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd12, 32'hFFFF_FFFF);
        rd(4'd2, v0, v1); chk("en after ro write R6", v0, 32'hFFFF_FFFF);
        rd(4'd3, v0, v1); chk("crit after ro write R6", v0, 32'h0001_0010);
        rd(4'd8, v0, v1); chk("vcfg after ro write R6", v0, 32'h0001_0000);
        rd(4'd12, v0, v1); chk("unused read R11", v0, 32'h0);
        wr(4'd4, 32'hA5A5_0F0F);
        rd(4'd4, v0, v1); chk("polarity store R11", v0, 32'hA5A5_0F0F);
        chk_outs("polarity no effect R11");

        // R9 vector idle
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd7, v0, v1); chk("vector idle R9", v0, 32'h0);
        chk("crit idle R5", {31'b0, crit0}, '0);

        // R12 random mix checked against the model each cycle
        for (int it = 0; it < 600; it++) begin
            int unsigned r;
            @(negedge clk);
            r = $urandom % 4;
            if (r == 0 || r == 2) begin
                addr  = 4'($urandom % 10);
                wdata = $urandom & $urandom;
                wr_en = 1'b1;
            end
            if (r == 1 || r == 2)
                irq_in[$urandom % N] = ~irq_in[$urandom % N];
            @(negedge clk);
            wr_en = 1'b0;
            chk_outs("random R12");
            chk_rd("random read R12", 4'($urandom % 10));
            chk_rd("random vector R7 R8", 4'd7);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule